// File: doc/BRIEF.md
# PLL Frequency Change Sequencer

This block holds the 32-bit control and status word of an on-chip PLL and walks it through safe transitions on command. A client issues one of five operations: bring the PLL out of reset and wait until it is locked, put it back into reset, turn its output on, turn its output off, or retune it to new feedback and output divider values. Lock indications arrive from the analog macro in another clock domain and are resynchronised before use.

A retune takes one of two routes. If the feedback divider changes, the PLL must re-acquire lock. The block first routes the reference clock around the PLL, then holds the PLL in reset while it loads both dividers, then releases reset. It waits for the first and then the second lock indication, and in its last write it enables the output and removes the bypass. If only the output divider changes, the bypass is held while that one field is rewritten and dropped afterwards, and reset is never touched.

The word is also exposed through a plain write/read port for setup while the block is idle. The block reports the current output frequency as a multiplier and a right-shift applied to the reference frequency. Each lock wait is guarded by a programmable timeout.

Top module: `pll_seq_ctrl`

## Requirements
- R1: After reset the control word (`pll_ctrl`) is 0x00000004, which means only the PLL reset bit (bit 2) is set. `busy`, `done`, `err_pulse` and `timeout_flag` are all low.
- R2: A bus write while idle stores `bus_wdata & 0x0FF71F7F`. The fields are: feedback divider bits 27:20, output divider 18:16, reference divider 12:8, range 6:4, internal bypass 3, PLL reset 2, external bypass 1, output enable 0. `bus_rdata` returns the stored word with bits 31:30 at zero, the resynchronised first lock flag in bit 28 and the second lock flag in bit 29. Each flag appears two clock edges after its input changes.
- R3: Opcode 1 (power-up) clears bit 2 in the accepting cycle. `busy` then stays high until the first lock flag and after it the second lock flag have been seen. A second lock flag alone does not end the wait. Completion gives a one-cycle `done`.
- R4: Opcode 2 sets bit 2, opcode 3 sets bit 0 and opcode 4 clears bit 0. Each is one write with a one-cycle `done` on the following cycle, and no other bit changes. Opcodes 0, 6 and 7 change nothing and raise no `done`.
- R5: Opcode 5 with a feedback divider different from the stored one writes, one per cycle, the following: external bypass set; reset set; both dividers loaded with reset still high; reset cleared. It then waits for the first and then the second lock flag. The final write sets output enable, clears external bypass and pulses `done`.
- R6: Opcode 5 with an unchanged feedback divider writes, one per cycle: external bypass set; output divider loaded; external bypass cleared together with `done`. Reset and the feedback divider stay unchanged.
- R7: `rate_mult`/`rate_shift` equal feedback divider + 1 and the output divider value. While external bypass (bit 1) is set they are 1 and 0.
- R8: While `busy` is high, commands and bus writes have no effect on the word. Each one yields `err_pulse` high for exactly the following cycle.
- R9: If a lock wait lasts `tmo_limit`+1 cycles, the block returns to idle with bit 2 set and sets `timeout_flag`. The flag stays set until the next command with a valid opcode is accepted.
- R10: When a command and a bus write arrive together while idle, the command executes, the bus write is dropped and `err_pulse` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Operation code |
| cmd_fb_div | input | 8 | Requested feedback divider (retune) |
| cmd_out_div | input | 3 | Requested output divider (retune) |
| tmo_limit | input | 16 | Lock wait limit in cycles |
| bus_wr | input | 1 | Bus write strobe |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Control word with lock flags |
| lock_async | input | 1 | First lock indication, asynchronous |
| long_lock_async | input | 1 | Second lock indication, asynchronous |
| pll_ctrl | output | 32 | Control word driven to the PLL |
| busy | output | 1 | A multi-cycle sequence is running |
| done | output | 1 | One-cycle completion pulse |
| err_pulse | output | 1 | One-cycle rejected-access pulse |
| timeout_flag | output | 1 | Sticky lock timeout |
| rate_mult | output | 9 | Output frequency multiplier of the reference |
| rate_shift | output | 3 | Output frequency right shift |

## Verification
Several properties are checked on every cycle. A sequencer change to the feedback divider only happens with reset and external bypass both high, and a change to the output divider only with external bypass high. A rejected access is followed by an error pulse, and the error pulse has no other cause. The timeout flag clears only on an accepted command. The reported rate collapses to the reference while bypassed. The bench scenarios are needed for the exact write order of each retune route, the ordering of the two lock waits, the timeout expiry and the recovery from it, and the command-over-bus priority.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
    localparam int WORD_W   = 32;
    localparam int FB_W     = 8;
    localparam int OD_W     = 3;
    localparam int FB_LSB   = 20;
    localparam int OD_LSB   = 16;
    localparam int LONG_BIT = 29;
    localparam int LOCK_BIT = 28;
    localparam int IBYP_BIT = 3;
    localparam int RST_BIT  = 2;
    localparam int XBYP_BIT = 1;
    localparam int EN_BIT   = 0;
    localparam logic [WORD_W-1:0] WR_MASK   = 32'h0FF7_1F7F;
    localparam logic [WORD_W-1:0] RESET_VAL = 32'h0000_0004;

    typedef enum logic [2:0] {
        OP_NONE       = 3'd0,
        OP_POWER_UP   = 3'd1,
        OP_POWER_DOWN = 3'd2,
        OP_ENABLE     = 3'd3,
        OP_DISABLE    = 3'd4,
        OP_RETUNE     = 3'd5
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_UP_LOCK,
        S_UP_LONG,
        S_RT_RST,
        S_RT_DIV,
        S_RT_REL,
        S_RT_LOCK,
        S_RT_LONG,
        S_RQ_DIV,
        S_RQ_FIN
    } seq_state_e;

    typedef struct packed {
        seq_state_e        state;
        logic [WORD_W-1:0] ctrl;
        logic [FB_W-1:0]   fb_pend;
        logic [OD_W-1:0]   od_pend;
        logic              done;
        logic              err;
        logic              tmo;
    } seq_regs_t;
endpackage

// File: rtl/pll_flag_sync.sv
module pll_flag_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
        end else begin
            pipe_q[0] <= d_async;
            for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
        end
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/pll_wait_timer.sv
module pll_wait_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run || restart)  cnt_d = '0;
        else if (cnt_q != limit) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && !restart && (cnt_q == limit);
endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc #(
    parameter int FBW = 8,
    parameter int ODW = 3
) (
    input  logic [FBW-1:0] fb_div,
    input  logic [ODW-1:0] od_div,
    input  logic           ext_bypass,
    output logic [FBW:0]   mult,
    output logic [ODW-1:0] shift
);
    always_comb begin
        if (ext_bypass) begin
            mult  = {{FBW{1'b0}}, 1'b1};
            shift = '0;
        end else begin
            mult  = {1'b0, fb_div} + 1'b1;
            shift = od_div;
        end
    end
endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
    import pll_seq_pkg::*;
#(
    parameter int TMO_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [FB_W-1:0]   cmd_fb_div,
    input  logic [OD_W-1:0]   cmd_out_div,
    input  logic [TMO_W-1:0]  tmo_limit,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              lock_async,
    input  logic              long_lock_async,
    output logic [WORD_W-1:0] pll_ctrl,
    output logic              busy,
    output logic              done,
    output logic              err_pulse,
    output logic              timeout_flag,
    output logic [FB_W:0]     rate_mult,
    output logic [OD_W-1:0]   rate_shift
);
    seq_regs_t r_d, r_q;
    logic [1:0] flags_s;
    logic       lock_s, long_s;
    logic       wait_run, wait_adv, wait_expired;
    logic [FB_W-1:0] cur_fb;

    pll_flag_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({long_lock_async, lock_async}),
        .q       (flags_s)
    );
    assign lock_s = flags_s[0];
    assign long_s = flags_s[1];

    pll_wait_timer #(.W(TMO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (wait_run),
        .restart (wait_adv),
        .limit   (tmo_limit),
        .expired (wait_expired)
    );

    assign cur_fb = r_q.ctrl[FB_LSB +: FB_W];

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        wait_run = 1'b0;
        wait_adv = 1'b0;

        if (r_q.state != S_IDLE && (cmd_valid || bus_wr)) r_d.err = 1'b1;

        unique case (r_q.state)
            S_IDLE: begin
                if (cmd_valid) begin
                    if (bus_wr) r_d.err = 1'b1;
                    unique case (op_e'(cmd_op))
                        OP_POWER_UP: begin
                            r_d.tmo           = 1'b0;
                            r_d.ctrl[RST_BIT] = 1'b0;
                            r_d.state         = S_UP_LOCK;
                        end
                        OP_POWER_DOWN: begin
                            r_d.tmo           = 1'b0;
                            r_d.ctrl[RST_BIT] = 1'b1;
                            r_d.done          = 1'b1;
                        end
                        OP_ENABLE: begin
                            r_d.tmo          = 1'b0;
                            r_d.ctrl[EN_BIT] = 1'b1;
                            r_d.done         = 1'b1;
                        end
                        OP_DISABLE: begin
                            r_d.tmo          = 1'b0;
                            r_d.ctrl[EN_BIT] = 1'b0;
                            r_d.done         = 1'b1;
                        end
                        OP_RETUNE: begin
                            r_d.tmo            = 1'b0;
                            r_d.fb_pend        = cmd_fb_div;
                            r_d.od_pend        = cmd_out_div;
                            r_d.ctrl[XBYP_BIT] = 1'b1;
                            r_d.state = (cmd_fb_div != cur_fb) ? S_RT_RST : S_RQ_DIV;
                        end
                        default: ;
                    endcase
                end else if (bus_wr) begin
                    r_d.ctrl = bus_wdata & WR_MASK;
                end
            end
            S_UP_LOCK, S_RT_LOCK: begin
                wait_run = 1'b1;
                if (lock_s) begin
                    wait_adv  = 1'b1;
                    r_d.state = (r_q.state == S_UP_LOCK) ? S_UP_LONG : S_RT_LONG;
                end else if (wait_expired) begin
                    r_d.ctrl[RST_BIT] = 1'b1;
                    r_d.tmo           = 1'b1;
                    r_d.state         = S_IDLE;
                end
            end
            S_UP_LONG, S_RT_LONG: begin
                wait_run = 1'b1;
                if (long_s) begin
                    wait_adv  = 1'b1;
                    r_d.done  = 1'b1;
                    r_d.state = S_IDLE;
                    if (r_q.state == S_RT_LONG) begin
                        r_d.ctrl[EN_BIT]   = 1'b1;
                        r_d.ctrl[XBYP_BIT] = 1'b0;
                    end
                end else if (wait_expired) begin
                    r_d.ctrl[RST_BIT] = 1'b1;
                    r_d.tmo           = 1'b1;
                    r_d.state         = S_IDLE;
                end
            end
            S_RT_RST: begin
                r_d.ctrl[RST_BIT] = 1'b1;
                r_d.state         = S_RT_DIV;
            end
            S_RT_DIV: begin
                r_d.ctrl[FB_LSB +: FB_W] = r_q.fb_pend;
                r_d.ctrl[OD_LSB +: OD_W] = r_q.od_pend;
                r_d.state                = S_RT_REL;
            end
            S_RT_REL: begin
                r_d.ctrl[RST_BIT] = 1'b0;
                r_d.state         = S_RT_LOCK;
            end
            S_RQ_DIV: begin
                r_d.ctrl[OD_LSB +: OD_W] = r_q.od_pend;
                r_d.state                = S_RQ_FIN;
            end
            S_RQ_FIN: begin
                r_d.ctrl[XBYP_BIT] = 1'b0;
                r_d.done           = 1'b1;
                r_d.state          = S_IDLE;
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state   <= S_IDLE;
            r_q.ctrl    <= RESET_VAL;
            r_q.fb_pend <= '0;
            r_q.od_pend <= '0;
            r_q.done    <= 1'b0;
            r_q.err     <= 1'b0;
            r_q.tmo     <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    pll_rate_calc #(.FBW(FB_W), .ODW(OD_W)) u_rate (
        .fb_div     (r_q.ctrl[FB_LSB +: FB_W]),
        .od_div     (r_q.ctrl[OD_LSB +: OD_W]),
        .ext_bypass (r_q.ctrl[XBYP_BIT]),
        .mult       (rate_mult),
        .shift      (rate_shift)
    );

    always_comb begin
        bus_rdata           = r_q.ctrl;
        bus_rdata[LOCK_BIT] = lock_s;
        bus_rdata[LONG_BIT] = long_s;
    end

    assign pll_ctrl     = r_q.ctrl;
    assign busy         = (r_q.state != S_IDLE);
    assign done         = r_q.done;
    assign err_pulse    = r_q.err;
    assign timeout_flag = r_q.tmo;
endmodule

// File: rtl/pll_seq_chk.sv
module pll_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        bus_wr,
    input logic        busy,
    input logic        err_pulse,
    input logic        timeout_flag,
    input logic [31:0] pll_ctrl,
    input logic [8:0]  rate_mult,
    input logic [2:0]  rate_shift
);
    a_r8_blocked_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        busy && (cmd_valid || bus_wr) |=> err_pulse);

    a_r10_err_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(busy) || $past(cmd_valid && bus_wr));

    a_r5_fb_loaded_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_ctrl[27:20] != $past(pll_ctrl[27:20])) && !$past(bus_wr)
        |-> pll_ctrl[2] && pll_ctrl[1]);

    a_r6_od_loaded_bypassed: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_ctrl[18:16] != $past(pll_ctrl[18:16])) && !$past(bus_wr)
        |-> pll_ctrl[1]);

    a_r9_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(timeout_flag) && !$past(cmd_valid && !busy) |-> timeout_flag);

    a_r7_bypass_rate: assert property (@(posedge clk) disable iff (!rst_n)
        pll_ctrl[1] |-> (rate_mult == 9'd1) && (rate_shift == 3'd0));
endmodule

bind pll_seq_ctrl pll_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .bus_wr       (bus_wr),
    .busy         (busy),
    .err_pulse    (err_pulse),
    .timeout_flag (timeout_flag),
    .pll_ctrl     (pll_ctrl),
    .rate_mult    (rate_mult),
    .rate_shift   (rate_shift)
);

// File: tb/pll_seq_ctrl_tb.sv
module pll_seq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [7:0]  cmd_fb_div = '0;
    logic [2:0]  cmd_out_div = '0;
    logic [15:0] tmo_limit = 16'd1000;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        lock_async = 1'b0;
    logic        long_lock_async = 1'b0;
    logic [31:0] pll_ctrl;
    logic        busy, done, err_pulse, timeout_flag;
    logic [8:0]  rate_mult;
    logic [2:0]  rate_shift;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pll_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_fb_div(cmd_fb_div), .cmd_out_div(cmd_out_div), .tmo_limit(tmo_limit),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lock_async(lock_async), .long_lock_async(long_lock_async),
        .pll_ctrl(pll_ctrl), .busy(busy), .done(done), .err_pulse(err_pulse),
        .timeout_flag(timeout_flag), .rate_mult(rate_mult), .rate_shift(rate_shift)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Drive one command for one edge; returns at the negedge after acceptance.
    task automatic issue(input logic [2:0] op, input logic [7:0] fb, input logic [2:0] od);
        cmd_valid = 1'b1; cmd_op = op; cmd_fb_div = fb; cmd_out_div = od;
        step();
        cmd_valid = 1'b0;
    endtask

    task automatic bus_write(input logic [31:0] data);
        bus_wr = 1'b1; bus_wdata = data;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic wait_done(input int limit, output logic seen);
        seen = 1'b0;
        for (int i = 0; i < limit; i++) begin
            step();
            if (done) begin seen = 1'b1; break; end
        end
    endtask

    task automatic t_reset();
        chk("R1 ctrl", pll_ctrl, 32'h0000_0004);
        chk("R1 flags", {28'd0, busy, done, err_pulse, timeout_flag}, 32'h0);
    endtask

    task automatic t_bus();
        bus_write(32'hFFFF_FFFF);
        chk("R2 masked write", bus_rdata, 32'h0FF7_1F7F);
        lock_async = 1'b1;
        step();
        chk("R2 lock after one edge", {31'd0, bus_rdata[28]}, 32'h0);
        step();
        chk("R2 lock after two edges", bus_rdata, 32'h1FF7_1F7F);
        lock_async = 1'b0;
        bus_write(32'h0102_0004);
        step(); step();
        chk("R2 readback", bus_rdata, 32'h0102_0004);
        chk("R7 rate mult", {23'd0, rate_mult}, 32'd17);
        chk("R7 rate shift", {29'd0, rate_shift}, 32'd2);
    endtask

    task automatic t_power_up();
        logic seen;
        issue(3'd1, 8'h0, 3'h0);
        chk("R3 reset cleared", pll_ctrl, 32'h0102_0000);
        chk("R3 busy", {31'd0, busy}, 32'd1);
        long_lock_async = 1'b1;
        for (int i = 0; i < 6; i++) step();
        chk("R3 long lock alone keeps waiting", {31'd0, busy}, 32'd1);
        lock_async = 1'b1;
        wait_done(10, seen);
        chk("R3 done", {31'd0, seen}, 32'd1);
        chk("R3 idle", {31'd0, busy}, 32'd0);
        chk("R3 ctrl", pll_ctrl, 32'h0102_0000);
    endtask

    task automatic t_enable_ops();
        issue(3'd3, 8'h0, 3'h0);
        chk("R4 enable ctrl", pll_ctrl, 32'h0102_0001);
        chk("R4 enable done", {31'd0, done}, 32'd1);
        issue(3'd4, 8'h0, 3'h0);
        chk("R4 disable ctrl", pll_ctrl, 32'h0102_0000);
        issue(3'd7, 8'h0, 3'h0);
        chk("R4 unknown op no effect", {pll_ctrl[31:2], busy, done}, {30'h0040_8000, 2'b00});
        issue(3'd3, 8'h0, 3'h0);
        chk("R4 enable again", pll_ctrl, 32'h0102_0001);
    endtask

    task automatic t_retune_new_fb();
        logic seen;
        lock_async = 1'b0; long_lock_async = 1'b0;
        issue(3'd5, 8'h20, 3'h1);
        chk("R5 bypass first", pll_ctrl, 32'h0102_0003);
        chk("R7 bypass rate", {20'd0, rate_mult, rate_shift}, {20'd0, 9'd1, 3'd0});
        step();
        chk("R5 reset second", pll_ctrl, 32'h0102_0007);
        step();
        chk("R5 dividers under reset", pll_ctrl, 32'h0201_0007);
        step();
        chk("R5 reset released", pll_ctrl, 32'h0201_0003);
        chk("R5 busy", {31'd0, busy}, 32'd1);
        // Blocked accesses during the lock wait.
        bus_wr = 1'b1; bus_wdata = 32'hFFFF_FFFF;
        cmd_valid = 1'b1; cmd_op = 3'd2;
        step();
        bus_wr = 1'b0; cmd_valid = 1'b0;
        chk("R8 err pulse", {31'd0, err_pulse}, 32'd1);
        step();
        chk("R8 err one cycle", {31'd0, err_pulse}, 32'd0);
        chk("R8 word untouched", pll_ctrl, 32'h0201_0003);
        lock_async = 1'b1;
        step(); step(); step();
        long_lock_async = 1'b1;
        wait_done(10, seen);
        chk("R5 done", {31'd0, seen}, 32'd1);
        chk("R5 final write", pll_ctrl, 32'h0201_0001);
        chk("R7 rate", {20'd0, rate_mult, rate_shift}, {20'd0, 9'd33, 3'd1});
    endtask

    task automatic t_retune_same_fb();
        issue(3'd5, 8'h20, 3'h3);
        chk("R6 bypass first", pll_ctrl, 32'h0201_0003);
        step();
        chk("R6 out div loaded", pll_ctrl, 32'h0203_0003);
        chk("R6 no done yet", {31'd0, done}, 32'd0);
        step();
        chk("R6 bypass dropped", pll_ctrl, 32'h0203_0001);
        chk("R6 done", {30'd0, done, busy}, 32'd2);
    endtask

    task automatic t_priority();
        bus_wr = 1'b1; bus_wdata = 32'hFFFF_FFFF;
        issue(3'd4, 8'h0, 3'h0);
        bus_wr = 1'b0;
        chk("R10 command wins", pll_ctrl, 32'h0203_0000);
        chk("R10 err", {31'd0, err_pulse}, 32'd1);
    endtask

    task automatic t_timeout();
        logic seen_done;
        logic hit;
        issue(3'd2, 8'h0, 3'h0);
        chk("R4 power down", pll_ctrl, 32'h0203_0004);
        lock_async = 1'b0; long_lock_async = 1'b0;
        tmo_limit = 16'd10;
        step(); step();
        issue(3'd1, 8'h0, 3'h0);
        seen_done = 1'b0; hit = 1'b0;
        for (int i = 0; i < 40; i++) begin
            step();
            if (done) seen_done = 1'b1;
            if (timeout_flag) begin hit = 1'b1; break; end
        end
        chk("R9 timeout raised", {31'd0, hit}, 32'd1);
        chk("R9 no done", {31'd0, seen_done}, 32'd0);
        chk("R9 reset reasserted", {pll_ctrl[31:1], busy}, 32'h0203_0004);
        step(); step();
        chk("R9 sticky", {31'd0, timeout_flag}, 32'd1);
        issue(3'd3, 8'h0, 3'h0);
        chk("R9 cleared by command", {31'd0, timeout_flag}, 32'd0);
    endtask

    initial begin : watchdog
        wait (cyc >= 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_bus();
        t_power_up();
        t_enable_ops();
        t_retune_new_fb();
        t_retune_same_fb();
        t_priority();
        t_timeout();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule